// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates column addresses for a memory burst, one address per clock. A start pulse loads a starting column, a length code and a wrap order. From the next clock the block walks through the burst, flagging each beat as valid and marking the final beat. Fixed-length bursts stay inside an aligned window the size of the burst. The sequential order counts upward and wraps inside that window. The interleaved order XORs the beat index into the low address bits.

A row-length mode ignores the window. It counts through every column of the row, wraps from the top column to column zero, and keeps running until a terminate strobe stops it. A terminate strobe also cuts short a fixed-length burst. A new start pulse at any time abandons the running burst, so a controller can issue a fresh random column on every clock. Row and bank selection, data transfer and command decoding belong to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: When `start_i` is sampled high at a clock edge, the following cycle shows beat 0 with `col_o` equal to the sampled `start_col_i` and `valid_o` high. Beat n appears n cycles later. A fixed-length burst gives exactly BL consecutive valid cycles.
- R3: The length code is decoded as 0→1, 1→2, 2→4, 3→8 beats, and 7→row mode. With `wrap_i`=0 (sequential), beat n has its low log2(BL) bits equal to (start low bits + n) mod BL, and its upper bits equal to those of the start column.
- R4: With `wrap_i`=1 (interleaved) and a fixed length, beat n has its low log2(BL) bits equal to the start's low bits XOR n, and its upper bits unchanged.
- R5: Length code 7 (row mode) gives beat n = (start + n) mod 2^COL_W whatever `wrap_i` is. The burst continues with no length limit until it is terminated.
- R6: In a fixed-length burst, `last_o` is high on beat BL-1 and on no earlier beat. `valid_o` falls on the next cycle unless a new start was sampled.
- R7: If `stop_i` is high during a valid beat, that beat shows `last_o`=1 and is the final beat, in both fixed-length and row mode.
- R8: A start sampled during an active burst abandons it, and the next cycle is beat 0 of the new burst. Start takes priority over a terminate or a final beat in the same cycle.
- R9: Length codes 4, 5 and 6 give a single-beat burst.
- R10: Whenever `valid_o` is 0, `col_o` and `last_o` are 0, and `stop_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new burst at this edge |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| wrap_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate: current beat becomes the last |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach is the wrap of a row-mode burst from the top column back to zero. To get there, the stimulus starts row bursts a few columns below the top, and it also runs one row burst for longer than a whole row. The other hard cases are collisions on one clock: a start together with a terminate, a start on a final beat, and a start in the middle of an interleaved burst. The stimulus drives each of these explicitly. A behavioural model in the bench, built from integer arithmetic, predicts every output on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_ROW   = 3'd7;

    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic       row_mode;
        order_e     order;
        logic [1:0] log_len;
    } burst_cfg_t;

    // Length code 0..3 selects 2**code beats, 7 selects whole-row mode,
    // the remaining codes fall back to a single beat.
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic wrap);
        burst_cfg_t c;
        c.row_mode = 1'b0;
        c.order    = ORDER_SEQ;
        c.log_len  = 2'd0;
        if (code == LEN_ROW) begin
            c.row_mode = 1'b1;
        end else if (code <= LEN_EIGHT) begin
            c.log_len = code[1:0];
            c.order   = wrap ? ORDER_XOR : ORDER_SEQ;
        end
        return c;
    endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_seq_pkg::*;
(
    input  logic [2:0]  code_i,
    input  logic        wrap_i,
    output burst_cfg_t  cfg_o
);

    always_comb begin
        cfg_o = decode_cfg(code_i, wrap_i);
    end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic             stop_i,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output burst_cfg_t       cfg_o,
    output logic             last_o
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             active_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] last_idx;
    logic             end_beat;

    always_comb begin
        last_idx = (ONE << cfg_q.log_len) - ONE;
        end_beat = active_q & (stop_i | (~cfg_q.row_mode & (cnt_q == last_idx)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            base_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            base_q   <= start_col_i;
            cfg_q    <= cfg_i;
        end else if (end_beat) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + ONE;
        end
    end

    assign active_o = active_q;
    assign cnt_o    = cnt_q;
    assign base_o   = base_q;
    assign cfg_o    = cfg_q;
    assign last_o   = end_beat;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             active_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] win_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    always_comb begin
        win_mask = cfg_i.row_mode ? '1 : ((ONE << cfg_i.log_len) - ONE);
        seq_col  = (base_i & ~win_mask) | ((base_i + cnt_i) & win_mask);
        xor_col  = base_i ^ (cnt_i & win_mask);
        if (!active_i)
            col_o = '0;
        else if (cfg_i.order == ORDER_XOR && !cfg_i.row_mode)
            col_o = xor_col;
        else
            col_o = seq_col;
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             wrap_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    burst_cfg_t       cfg_in;
    burst_cfg_t       cfg_cur;
    logic             active;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;

    burst_len_decode u_dec (
        .code_i (len_code_i),
        .wrap_i (wrap_i),
        .cfg_o  (cfg_in)
    );

    burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .cfg_i       (cfg_in),
        .stop_i      (stop_i),
        .active_o    (active),
        .cnt_o       (cnt),
        .base_o      (base),
        .cfg_o       (cfg_cur),
        .last_o      (last_o)
    );

    burst_col_gen #(.COL_W(COL_W)) u_col (
        .active_i (active),
        .base_i   (base),
        .cnt_i    (cnt),
        .cfg_i    (cfg_cur),
        .col_o    (col_o)
    );

    assign valid_o = active;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_o,
    input  logic             valid_o,
    input  logic             last_o
);

    logic             chk_fixed;
    int               chk_bl;
    int               chk_cnt;
    logic [COL_W-1:0] chk_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_fixed <= 1'b0;
            chk_bl    <= 1;
            chk_cnt   <= 0;
            chk_mask  <= '0;
        end else if (start_i) begin
            chk_cnt <= 0;
            if (len_code_i == 3'd7) begin
                chk_fixed <= 1'b0;
                chk_bl    <= 0;
                chk_mask  <= '1;
            end else if (len_code_i <= 3'd3) begin
                chk_fixed <= 1'b1;
                chk_bl    <= 1 << len_code_i;
                chk_mask  <= COL_W'((1 << len_code_i) - 1);
            end else begin
                chk_fixed <= 1'b1;
                chk_bl    <= 1;
                chk_mask  <= '0;
            end
        end else if (valid_o) begin
            chk_cnt <= chk_cnt + 1;
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (col_o == '0 && !last_o));

    assert_start_loads_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    assert_beats_gapless_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i) |=> valid_o);

    assert_ends_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && last_o && !start_i) |=> !valid_o);

    assert_last_on_final_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && chk_fixed && chk_cnt == chk_bl - 1) |-> last_o);

    assert_stop_marks_last_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && stop_i) |-> last_o);

    // R3 and R4: the bits above the burst window never move inside a burst
    assert_window_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && chk_fixed)
        |=> ((col_o & ~chk_mask) == ($past(col_o) & ~chk_mask)));

    assert_row_step_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && !chk_fixed)
        |=> (col_o == $past(col_o) + COL_W'(1)));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    localparam int COL_W = 9;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             wrap_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag     = "R1";

    // behavioural model state
    bit m_act = 0;
    int m_base = 0;
    int m_n = 0;
    int m_bl = 1;     // 0 means row mode
    bit m_ilv = 0;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .wrap_i      (wrap_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    always #5 clk = ~clk;

    function automatic int exp_col();
        int lo;
        int hi;
        if (!m_act) return 0;
        if (m_bl == 0) return (m_base + m_n) % ROW;
        lo = m_base % m_bl;
        hi = m_base - lo;
        if (m_ilv) return hi + (lo ^ m_n);
        return hi + ((lo + m_n) % m_bl);
    endfunction

    function automatic bit exp_last(input bit stp);
        return m_act && (stp || (m_bl != 0 && m_n == m_bl - 1));
    endfunction

    // Called at a falling edge: apply inputs, check outputs, advance model.
    task automatic cycle(input bit s, input int c, input int code, input bit w, input bit stp);
        int ec;
        bit el;
        start_i     = s;
        start_col_i = COL_W'(c);
        len_code_i  = 3'(code);
        wrap_i      = w;
        stop_i      = stp;
        #1;
        ec = exp_col();
        el = exp_last(stp);
        n_tests++;
        if (valid_o !== m_act || last_o !== el || int'(col_o) != ec) begin
            n_fail++;
            $display("FAIL %s: col=%0d valid=%0b last=%0b expected col=%0d valid=%0b last=%0b",
                     tag, col_o, valid_o, last_o, ec, m_act, el);
        end
        if (!rst) begin
            if (s) begin
                m_act  = 1;
                m_n    = 0;
                m_base = c % ROW;
                if (code == 7) begin
                    m_bl = 0;
                    m_ilv = 0;
                end else if (code <= 3) begin
                    m_bl = 1 << code;
                    m_ilv = w;
                end else begin
                    m_bl = 1;
                    m_ilv = w;
                end
            end else if (el) begin
                m_act = 0;
                m_n   = 0;
            end else if (m_act) begin
                m_n = (m_n + 1) % ROW;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int k, input bit stp);
        for (int i = 0; i < k; i++) cycle(0, 0, 0, 0, stp);
    endtask

    task automatic burst(input int c, input int code, input bit w, input int tail);
        cycle(1, c, code, w, 0);
        idle(tail, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        idle(3, 0);
        rst = 1'b0;
        idle(2, 0);

        tag = "R2";
        for (int code = 0; code <= 3; code++) burst(16 + code, code, 0, 10);

        tag = "R3";
        burst(29, 3, 0, 10);
        burst(30, 2, 0, 6);
        burst(255, 1, 0, 4);

        tag = "R4";
        burst(29, 3, 1, 10);
        burst(11, 2, 1, 6);
        burst(7, 1, 1, 4);
        burst(500, 3, 1, 10);

        tag = "R5";
        cycle(1, 508, 7, 1, 0);
        idle(10, 0);
        idle(1, 1);
        idle(3, 0);
        cycle(1, 3, 7, 0, 0);
        idle(600, 0);
        idle(1, 1);
        idle(2, 0);

        tag = "R6";
        cycle(1, 40, 2, 0, 0);
        idle(3, 0);
        cycle(1, 80, 3, 1, 0);   // start on final beat of previous burst
        idle(10, 0);

        tag = "R7";
        cycle(1, 100, 3, 0, 0);
        idle(3, 0);
        idle(1, 1);
        idle(3, 0);
        cycle(1, 101, 0, 0, 0);
        idle(1, 1);
        idle(2, 0);

        tag = "R8";
        cycle(1, 200, 3, 0, 0);
        idle(2, 0);
        cycle(1, 333, 3, 1, 0);
        idle(3, 0);
        cycle(1, 64, 2, 0, 1);   // start with terminate in the same cycle
        idle(6, 0);
        cycle(1, 10, 7, 0, 0);
        idle(4, 0);
        cycle(1, 20, 1, 0, 0);
        idle(4, 0);

        tag = "R9";
        for (int code = 4; code <= 6; code++) burst(50 + code, code, code[0], 3);

        tag = "R10";
        idle(4, 1);
        burst(9, 1, 0, 2);
        idle(3, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule